// File: doc/BRIEF.md
# 128-bit SIMD Integer Vector ALU

This block is a vector execution unit for a 128-bit datapath. Two source operands, `a` and `b`, enter together with a 3-bit operation code. The unit forms one of five lane-wise results: a saturating unsigned add on eight 16-bit lanes, a saturating unsigned subtract on sixteen 8-bit lanes, a signed greater-than compare on sixteen 8-bit lanes that yields byte masks, a bitwise AND of `a` with the inverse of `b`, and a left rotate of each byte of `a` by an amount taken from the matching byte of `b`. Lanes are fully independent. No carry, borrow or rotated bit moves from one lane into another. Lane 0 occupies the least significant bits, and lane numbers rise toward bit 127.

The result is registered. A small output-stage state machine tracks whether the result register holds a fresh value. It has two states. ST_EMPTY means no result was produced on the last edge. ST_FULL means a result was captured on the last edge. The transition from either state goes to ST_FULL when `in_valid` is high and to ST_EMPTY when it is low. `out_valid` is high exactly in ST_FULL.

A sticky saturation flag records whether any lane of either saturating operation has clamped. The flag stays set until `sat_clear` or reset clears it.

Top module: `vau_simd_alu`

## Requirements
- R1: With op code 0, each 16-bit lane i (bits 16i+15..16i) of the result is the unsigned sum of lane i of `a` and lane i of `b`. A lane whose sum exceeds 0xFFFF gives 0xFFFF instead, and the other lanes are unaffected.
- R2: With op code 1, each 8-bit lane i (bits 8i+7..8i) of the result is lane i of `a` minus lane i of `b`, both taken as unsigned. A lane where `b` is larger gives 0x00. Equal lanes also give 0x00, but that case is not a clamp.
- R3: With op code 2, result byte i is 0xFF when byte i of `a` is strictly greater than byte i of `b` as two's-complement numbers, and 0x00 otherwise, including when the bytes are equal.
- R4: With op code 3, the result is `a & ~b` over all 128 bits.
- R5: With op code 4, result byte i is byte i of `a` rotated left by the value in bits 2..0 of byte i of `b`. Bits 7..3 of that byte of `b` have no effect.
- R6: Op codes 5, 6 and 7 produce an all-zero result.
- R7: `result` and `out_valid` update on the clock edge that samples `in_valid` high, so they appear one cycle later. On an edge where `in_valid` is low, `out_valid` goes low and `result` keeps its previous value.
- R8: `sat_flag` is set on an edge where `in_valid` is high with op code 0 or 1 and any lane clamps. It stays set otherwise, and clears on an edge where `sat_clear` is high and no new clamp occurs. When a clamp and `sat_clear` happen on the same edge, the set takes priority.
- R9: Synchronous active-high `rst` clears `out_valid`, `sat_flag` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation code: 0 add-sat halfword, 1 sub-sat byte, 2 signed byte compare, 3 AND-with-complement, 4 byte rotate-left |
| a | input | 128 | First source operand |
| b | input | 128 | Second source operand |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result register holds a value captured on the last edge |
| result | output | 128 | Registered vector result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
Every result, the `out_valid` flag and the saturation flag are due one clock edge after the cycle in which `in_valid`, `op`, the operands and `sat_clear` are presented. The bench drives a stimulus on a falling edge and lets one rising edge pass. It compares all three outputs at the next falling edge against values computed by its own lane functions and by its own model of the sticky flag. Idle cycles are checked in the same way: one edge after `in_valid` drops, `out_valid` must be low and `result` must still hold the earlier value.

// File: rtl/vau_pkg.sv
package vau_pkg;

    typedef enum logic [2:0] {
        OP_HADDS  = 3'd0,
        OP_BSUBS  = 3'd1,
        OP_BCMPGT = 3'd2,
        OP_ANDC   = 3'd3,
        OP_BROTL  = 3'd4
    } vau_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } vau_state_e;

endpackage

// File: rtl/vau_add_sat.sv
module vau_add_sat #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              sat_any
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] clamp;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lo;
        logic [LANE_W:0]   wide;
        always_comb begin
            la   = a[i*LANE_W +: LANE_W];
            lb   = b[i*LANE_W +: LANE_W];
            wide = {1'b0, la} + {1'b0, lb};
            clamp[i] = wide[LANE_W];
            lo   = clamp[i] ? {LANE_W{1'b1}} : wide[LANE_W-1:0];
            sum[i*LANE_W +: LANE_W] = lo;
        end
        // R1
        always_comb begin
            lane_ge_chk: assert (lo >= la && lo >= lb);
        end
    end

    assign sat_any = |clamp;

endmodule

// File: rtl/vau_sub_sat.sv
module vau_sub_sat #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] diff,
    output logic              sat_any
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] clamp;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lo;
        logic [LANE_W:0]   wide;
        always_comb begin
            la   = a[i*LANE_W +: LANE_W];
            lb   = b[i*LANE_W +: LANE_W];
            wide = {1'b0, la} - {1'b0, lb};
            clamp[i] = wide[LANE_W];
            lo   = clamp[i] ? {LANE_W{1'b0}} : wide[LANE_W-1:0];
            diff[i*LANE_W +: LANE_W] = lo;
        end
        // R2
        always_comb begin
            lane_le_chk: assert (lo <= la);
        end
    end

    assign sat_any = |clamp;

endmodule

// File: rtl/vau_byte_misc.sv
module vau_byte_misc #(
    parameter int DATA_W = 128,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] cmp_mask,
    output logic [DATA_W-1:0] rot
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int ROT_W = $clog2(BYTE_W);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0]   la, lb, lr;
        logic [2*BYTE_W-1:0] dbl;
        logic [ROT_W-1:0]    amt;
        always_comb begin
            la  = a[i*BYTE_W +: BYTE_W];
            lb  = b[i*BYTE_W +: BYTE_W];
            amt = lb[ROT_W-1:0];
            dbl = {la, la} << amt;
            lr  = dbl[2*BYTE_W-1 -: BYTE_W];
            rot[i*BYTE_W +: BYTE_W] = lr;
            cmp_mask[i*BYTE_W +: BYTE_W] =
                ($signed(la) > $signed(lb)) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
        end
        // R5
        always_comb begin
            rot_bits_kept_chk: assert ($countones(lr) == $countones(la));
        end
    end

endmodule

// File: rtl/vau_simd_alu.sv
module vau_simd_alu
    import vau_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sat_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int HALF_W = 2 * BYTE_W;

    logic [DATA_W-1:0] add_res, sub_res, cmp_res, rot_res, op_res;
    logic              add_sat, sub_sat, sat_event;
    vau_state_e        state_q, state_d;
    logic [DATA_W-1:0] result_q;
    logic              sat_q;

    vau_add_sat #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_add (
        .a(a), .b(b), .sum(add_res), .sat_any(add_sat)
    );

    vau_sub_sat #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_sub (
        .a(a), .b(b), .diff(sub_res), .sat_any(sub_sat)
    );

    vau_byte_misc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_misc (
        .a(a), .b(b), .cmp_mask(cmp_res), .rot(rot_res)
    );

    always_comb begin
        op_res    = '0;
        sat_event = 1'b0;
        case (vau_op_e'(op))
            OP_HADDS: begin
                op_res    = add_res;
                sat_event = add_sat;
            end
            OP_BSUBS: begin
                op_res    = sub_res;
                sat_event = sub_sat;
            end
            OP_BCMPGT: op_res = cmp_res;
            OP_ANDC:   op_res = a & ~b;
            OP_BROTL:  op_res = rot_res;
            default:   op_res = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_EMPTY;
            result_q <= '0;
            sat_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                result_q <= op_res;
            end
            if (in_valid && sat_event) begin
                sat_q <= 1'b1;
            end else if (sat_clear) begin
                sat_q <= 1'b0;
            end
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        result    = result_q;
        sat_flag  = sat_q;
    end

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R8
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> sat_flag);

    // R8
    sat_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_event) |=> sat_flag);

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 3'd4) |=> (result == '0));

endmodule

// File: tb/vau_simd_alu_test.sv
`timescale 1ns/1ps
module vau_simd_alu_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [127:0] a = '0;
    logic [127:0] b = '0;
    logic         sat_clear = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         sat_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic         exp_flag = 1'b0;
    logic [127:0] last_res = '0;

    always #4 clk = ~clk;

    vau_simd_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .sat_clear(sat_clear), .out_valid(out_valid), .result(result),
        .sat_flag(sat_flag)
    );

    function automatic logic [127:0] model_res(input logic [2:0] o,
                                               input logic [127:0] x,
                                               input logic [127:0] y);
        logic [127:0] r;
        r = '0;
        case (o)
            3'd0: for (int i = 0; i < 8; i++) begin
                int s;
                s = int'(x[i*16 +: 16]) + int'(y[i*16 +: 16]);
                r[i*16 +: 16] = (s > 65535) ? 16'hFFFF : s[15:0];
            end
            3'd1: for (int i = 0; i < 16; i++) begin
                int d;
                d = int'(x[i*8 +: 8]) - int'(y[i*8 +: 8]);
                r[i*8 +: 8] = (d < 0) ? 8'h00 : d[7:0];
            end
            3'd2: for (int i = 0; i < 16; i++) begin
                int sa, sb;
                sa = int'(x[i*8 +: 8]); if (sa > 127) sa = sa - 256;
                sb = int'(y[i*8 +: 8]); if (sb > 127) sb = sb - 256;
                r[i*8 +: 8] = (sa > sb) ? 8'hFF : 8'h00;
            end
            3'd3: r = x & ~y;
            3'd4: for (int i = 0; i < 16; i++) begin
                logic [7:0] v;
                v = x[i*8 +: 8];
                for (int k = 0; k < int'(y[i*8 +: 3]); k++) v = {v[6:0], v[7]};
                r[i*8 +: 8] = v;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic bit model_clamp(input logic [2:0] o,
                                       input logic [127:0] x,
                                       input logic [127:0] y);
        bit c;
        c = 1'b0;
        if (o == 3'd0)
            for (int i = 0; i < 8; i++)
                if (int'(x[i*16 +: 16]) + int'(y[i*16 +: 16]) > 65535) c = 1'b1;
        if (o == 3'd1)
            for (int i = 0; i < 16; i++)
                if (x[i*8 +: 8] < y[i*8 +: 8]) c = 1'b1;
        return c;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic do_op(input logic [2:0] o, input logic [127:0] x,
                         input logic [127:0] y, input logic clr);
        logic [127:0] er;
        in_valid = 1'b1; op = o; a = x; b = y; sat_clear = clr;
        er = model_res(o, x, y);
        if (model_clamp(o, x, y)) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        @(negedge clk);
        chk(result == er, tag_of(o), "result", result, er);
        chk(out_valid == 1'b1, "R7", "out_valid after op", 128'(out_valid), 128'd1);
        chk(sat_flag == exp_flag, "R8", "sat_flag", 128'(sat_flag), 128'(exp_flag));
        last_res = er;
    endtask

    task automatic do_idle(input logic clr);
        in_valid = 1'b0; sat_clear = clr;
        a = {$urandom(), $urandom(), $urandom(), $urandom()};
        op = 3'($urandom());
        if (clr) exp_flag = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid idle", 128'(out_valid), 128'd0);
        chk(result == last_res, "R7", "result held", result, last_res);
        chk(sat_flag == exp_flag, "R8", "sat_flag idle", 128'(sat_flag), 128'(exp_flag));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog expired act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        in_valid = 1'b1; a = rnd128(); b = rnd128(); op = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "out_valid reset", 128'(out_valid), 128'd0);
        chk(sat_flag == 1'b0, "R9", "sat_flag reset", 128'(sat_flag), 128'd0);
        chk(result == '0, "R9", "result reset", result, '0);

        // R1 no-clamp full-range sum leaves flag clear
        do_op(3'd0, {8{16'h7FFF}}, {8{16'h8000}}, 1'b0);
        // R1 lane 0 clamps, lane 1 untouched
        do_op(3'd0, {{6{16'h0000}}, 16'h1234, 16'hFFFF}, {{6{16'h0000}}, 16'h0001, 16'h0001}, 1'b0);
        // R8 clear on idle
        do_idle(1'b1);
        // R2 borrow in lane 0 only, equal lanes no clamp
        do_op(3'd1, {{15{8'h55}}, 8'h00}, {{15{8'h55}}, 8'h00}, 1'b0);
        do_op(3'd1, {{14{8'h10}}, 8'h20, 8'h00}, {{14{8'h01}}, 8'h01, 8'h01}, 1'b0);
        // R8 set wins over clear on same edge
        do_op(3'd1, {16{8'h00}}, {16{8'h01}}, 1'b1);
        do_idle(1'b0);
        // R3 extremes and equality
        do_op(3'd2, {{13{8'h05}}, 8'h80, 8'h80, 8'h7F}, {{13{8'h05}}, 8'h7F, 8'h80, 8'h80}, 1'b1);
        // R4
        do_op(3'd3, {4{32'hF0F0_AAAA}}, {4{32'hFF00_0F0F}}, 1'b0);
        // R5 upper amount bits ignored
        do_op(3'd4, {{14{8'hC3}}, 8'h81, 8'h81}, {{14{8'hFF}}, 8'hF8, 8'hF9}, 1'b0);
        // R6 unused codes
        for (int c = 5; c < 8; c++) do_op(3'(c), rnd128(), rnd128(), 1'b0);
        do_idle(1'b0);

        for (int n = 0; n < 600; n++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) do_idle(1'($urandom()));
            else do_op(o, rnd128(), rnd128(), 1'($urandom_range(0, 3) == 0));
        end

        // R9 mid-run reset clears flag and valid
        do_op(3'd1, {16{8'h00}}, {16{8'hFF}}, 1'b0);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 128'(out_valid), 128'd0);
        chk(sat_flag == 1'b0, "R9", "sat_flag after reset", 128'(sat_flag), 128'd0);
        chk(result == '0, "R9", "result after reset", result, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule